// File: doc/BRIEF.md
# Multi-Digit Ripple-Blanking Seven-Segment Decoder

This block turns a packed binary-coded-decimal value into segment drive patterns for a row of common-anode seven-segment digits. The segment lines are active low. Each digit has its own decoding slice. The slices form a chain from the most significant digit down to the least significant one. The blanking state passes down this chain, so zeros ahead of the first nonzero digit go dark. Zeros that follow a nonzero digit are still shown.

An external active-low blank input starts the chain. Tying it low hides leading zeros. Driving it high shows every digit, leading zeros included. The least significant digit never goes dark for being zero, so a value of all zeros still shows a single 0. The final chain output reports whether the whole group was blanked, and a further display group can use it as its own blank input.

A parameter adds an output register stage. This stage has a synchronous active-high reset that turns every segment off.

Top module: `rb_digit_decoder`

## Requirements
- R1: Each valid digit 0 to 9 drives its 7-bit pattern with segment a at bit 6 down to segment g at bit 0. A 0 lights a segment. The patterns are: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100.
- R2: A digit code from 1010 to 1111 drives 1111111 (all segments off). For blanking purposes it counts as a nonzero digit.
- R3: Digit i is read from bcd_in[4i+3:4i] and drives seg_out[7i+6:7i]. Digit DIGITS-1 is the most significant.
- R4: A slice whose chain input is 0 and whose digit is 0000 (other than the least significant slice) drives 1111111 and passes 0 down the chain.
- R5: A slice whose chain input is 1 shows a 0000 digit as the zero pattern 0000001.
- R6: A slice's chain output is 1 whenever its chain input is 1 or its digit is nonzero. The chain output of the least significant slice is rbo_out_n.
- R7: blank_in_n is the chain input of the most significant digit. Each slice's chain output is the chain input of the next less significant digit. The result is that leading zeros are blank and internal zeros are shown.
- R8: The least significant digit always shows 0000 as 0000001, even when its chain input is 0.
- R9: With REGISTERED=1, all outputs follow the inputs one clock later. A synchronous reset drives every segment line to 1 and drives rbo_out_n to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| bcd_in | input | 4*DIGITS | Packed BCD value, most significant digit in the top nibble |
| blank_in_n | input | 1 | Active-low blank input feeding the most significant digit |
| seg_out | output | 7*DIGITS | Active-low segment patterns, 7 bits per digit |
| rbo_out_n | output | 1 | Active-low chain output of the least significant digit |

## Verification
The hardest case to reach is a long run of leading zeros that ends at an internal zero. The blank state has to travel through several slices, and it must stop at the first nonzero digit even when that digit holds an invalid code. A second hard case is an all-zero value with blank_in_n low. There the least significant slice must show its zero while rbo_out_n still goes low. The stimulus covers both cases with hand-built values such as 0x0102, 0xF0F0 and 0x0000. After that it runs random values in which about one nibble in three is zero, so runs of zeros of every length and position come up. A reset is also applied in the middle of the run.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    typedef logic [6:0] seg_t;

    localparam seg_t SEG_OFF = 7'b1111111;

    function automatic seg_t bcd_to_seg(input logic [3:0] code);
        seg_t pat;
        case (code)
            4'd0:    pat = 7'b0000001;
            4'd1:    pat = 7'b1001111;
            4'd2:    pat = 7'b0010010;
            4'd3:    pat = 7'b0000110;
            4'd4:    pat = 7'b1001100;
            4'd5:    pat = 7'b0100100;
            4'd6:    pat = 7'b0100000;
            4'd7:    pat = 7'b0001111;
            4'd8:    pat = 7'b0000000;
            4'd9:    pat = 7'b0000100;
            default: pat = SEG_OFF;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/rbd_digit_slice.sv
module rbd_digit_slice
    import rbd_pkg::*;
(
    input  logic [3:0] digit,
    input  logic       rbi_n,
    input  logic       keep_zero,
    output seg_t       seg,
    output logic       rbo_n
);
    logic is_zero;
    logic blank;

    always_comb begin
        is_zero = (digit == 4'd0);
        blank   = is_zero && !rbi_n && !keep_zero;
        seg     = blank ? SEG_OFF : bcd_to_seg(digit);
        rbo_n   = rbi_n || !is_zero;
    end
endmodule

// File: rtl/rbd_out_stage.sv
module rbd_out_stage #(
    parameter int          W          = 8,
    parameter bit          REGISTERED = 1'b1,
    parameter logic [W-1:0] RST_VAL   = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= d;
            end
        end else begin : g_pass
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/rb_digit_decoder.sv
module rb_digit_decoder
    import rbd_pkg::*;
#(
    parameter int DIGITS     = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [4*DIGITS-1:0]   bcd_in,
    input  logic                  blank_in_n,
    output logic [7*DIGITS-1:0]   seg_out,
    output logic                  rbo_out_n
);
    localparam int BCD_W = 4 * DIGITS;
    localparam int SEG_W = 7 * DIGITS;
    localparam int OUT_W = SEG_W + 1;

    logic [DIGITS:0]  chain_n;
    logic [SEG_W-1:0] seg_comb;
    logic [OUT_W-1:0] stage_q;

    assign chain_n[DIGITS] = blank_in_n;

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_digit
            seg_t slice_seg;
            rbd_digit_slice u_slice (
                .digit     (bcd_in[4*i +: 4]),
                .rbi_n     (chain_n[i+1]),
                .keep_zero ((i == 0) ? 1'b1 : 1'b0),
                .seg       (slice_seg),
                .rbo_n     (chain_n[i])
            );
            assign seg_comb[7*i +: 7] = slice_seg;
        end
    endgenerate

    rbd_out_stage #(
        .W          (OUT_W),
        .REGISTERED (REGISTERED),
        .RST_VAL    ({OUT_W{1'b1}})
    ) u_out (
        .clk (clk),
        .rst (rst),
        .d   ({chain_n[0], seg_comb}),
        .q   (stage_q)
    );

    assign seg_out   = stage_q[SEG_W-1:0];
    assign rbo_out_n = stage_q[SEG_W];

    logic unused_w;
    assign unused_w = (BCD_W == 0);
endmodule

// File: rtl/rb_digit_decoder_chk.sv
module rb_digit_decoder_chk #(
    parameter int DIGITS     = 4,
    parameter bit REGISTERED = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic [4*DIGITS-1:0] bcd_in,
    input logic                blank_in_n,
    input logic [7*DIGITS-1:0] seg_out,
    input logic                rbo_out_n
);
    logic [4*DIGITS-1:0] q_bcd;
    logic                q_blank;
    logic                q_valid;

    always_ff @(posedge clk) begin
        q_bcd   <= bcd_in;
        q_blank <= blank_in_n;
        q_valid <= !rst;
    end

    logic [4*DIGITS-1:0] ref_bcd;
    logic                ref_blank;
    logic                gate;
    assign ref_bcd   = REGISTERED ? q_bcd : bcd_in;
    assign ref_blank = REGISTERED ? q_blank : blank_in_n;
    assign gate      = REGISTERED ? q_valid : 1'b1;

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_inv
            a_r2_invalid_blank: assert property (@(posedge clk) disable iff (rst)
                (gate && ref_bcd[4*i +: 4] > 4'd9) |-> (seg_out[7*i +: 7] == 7'b1111111));
        end
    endgenerate

    a_r8_lsd_zero_shown: assert property (@(posedge clk) disable iff (rst)
        (gate && ref_bcd[3:0] == 4'd0) |-> (seg_out[6:0] == 7'b0000001));

    a_r6_rbo_high: assert property (@(posedge clk) disable iff (rst)
        (gate && (ref_blank || ref_bcd != '0)) |-> rbo_out_n);

    a_r4_group_blank_rbo: assert property (@(posedge clk) disable iff (rst)
        (gate && !ref_blank && ref_bcd == '0) |-> !rbo_out_n);

    a_r5_msd_zero_shown: assert property (@(posedge clk) disable iff (rst)
        (gate && ref_blank && ref_bcd[4*DIGITS-1 -: 4] == 4'd0)
            |-> (seg_out[7*DIGITS-1 -: 7] == 7'b0000001));

    generate
        if (DIGITS > 1) begin : g_upper
            a_r7_leading_blank: assert property (@(posedge clk) disable iff (rst)
                (gate && !ref_blank && ref_bcd == '0)
                    |-> (&seg_out[7*DIGITS-1:7]));
        end
        if (REGISTERED) begin : g_rst
            a_r9_reset_blank: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> ((&seg_out) && rbo_out_n));
        end
    endgenerate
endmodule

bind rb_digit_decoder rb_digit_decoder_chk #(
    .DIGITS     (DIGITS),
    .REGISTERED (REGISTERED)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bcd_in     (bcd_in),
    .blank_in_n (blank_in_n),
    .seg_out    (seg_out),
    .rbo_out_n  (rbo_out_n)
);

// File: tb/sim_rb_digit_decoder.sv
module sim_rb_digit_decoder;
    localparam int N = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [4*N-1:0]   bcd_in = '0;
    logic             blank_in_n = 1'b0;
    logic [7*N-1:0]   seg_out;
    logic             rbo_out_n;

    always #5 clk = ~clk;

    rb_digit_decoder #(.DIGITS(N), .REGISTERED(1'b1)) u0 (
        .clk(clk), .rst(rst), .bcd_in(bcd_in), .blank_in_n(blank_in_n),
        .seg_out(seg_out), .rbo_out_n(rbo_out_n)
    );

    int tests = 0;
    int fails = 0;
    bit pend_valid = 1'b0;
    logic [7*N:0] pend;
    string pend_tag = "";

    function automatic logic [6:0] shape(input int d);
        case (d)
            0: return 7'b0000001;
            1: return 7'b1001111;
            2: return 7'b0010010;
            3: return 7'b0000110;
            4: return 7'b1001100;
            5: return 7'b0100100;
            6: return 7'b0100000;
            7: return 7'b0001111;
            8: return 7'b0000000;
            9: return 7'b0000100;
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic logic [7*N:0] model(input logic [4*N-1:0] v, input logic bn);
        logic [7*N-1:0] s;
        bit shown = bn;
        for (int i = N - 1; i >= 0; i--) begin
            int d = int'(v[4*i +: 4]);
            if (d == 0 && !shown && i != 0) s[7*i +: 7] = 7'b1111111;
            else                            s[7*i +: 7] = shape(d);
            if (d != 0) shown = 1'b1;
        end
        return {(bn || v != '0), s};
    endfunction

    task automatic check_out();
        if (pend_valid) begin
            tests++;
            if ({rbo_out_n, seg_out} !== pend) begin
                fails++;
                $display("FAIL %s actual rbo=%b seg=%b expected rbo=%b seg=%b",
                         pend_tag, rbo_out_n, seg_out, pend[7*N], pend[7*N-1:0]);
            end
        end
    endtask

    task automatic step(input logic [4*N-1:0] v, input logic bn, input logic r, input string tag);
        @(negedge clk);
        check_out();
        bcd_in     = v;
        blank_in_n = bn;
        rst        = r;
        pend       = r ? {(7*N+1){1'b1}} : model(v, bn);
        pend_tag   = tag;
        pend_valid = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R9 reset state
        step('0, 1'b1, 1'b1, "R9_reset");
        step(16'h1234, 1'b1, 1'b1, "R9_reset");
        // R1 every valid pattern in every position
        for (int d = 0; d < 10; d++) begin
            logic [3:0] n = 4'(d);
            step({n, n, n, n}, 1'b1, 1'b0, "R1");
        end
        // R3 digit placement
        step(16'h1234, 1'b1, 1'b0, "R3");
        step(16'h9001, 1'b1, 1'b0, "R3");
        // R2 invalid codes
        step(16'hABCD, 1'b0, 1'b0, "R2");
        step(16'hF0F0, 1'b0, 1'b0, "R2");
        step(16'h00E0, 1'b0, 1'b0, "R2");
        // R4 leading zero blanking
        step(16'h0005, 1'b0, 1'b0, "R4");
        // R5 zeros shown with chain high
        step(16'h0005, 1'b1, 1'b0, "R5");
        // R6 chain output
        step(16'h0000, 1'b0, 1'b0, "R6");
        step(16'h0000, 1'b1, 1'b0, "R6");
        step(16'h0010, 1'b0, 1'b0, "R6");
        // R7 internal zeros shown after the first nonzero digit
        step(16'h0102, 1'b0, 1'b0, "R7");
        step(16'h1000, 1'b0, 1'b0, "R7");
        // R8 lone final zero
        step(16'h0000, 1'b0, 1'b0, "R8");
        // R9 reset in mid run
        step(16'h4321, 1'b0, 1'b1, "R9_midrun");
        step(16'h4321, 1'b0, 1'b0, "R9_release");
        // R7 random values rich in zeros
        for (int k = 0; k < 400; k++) begin
            logic [4*N-1:0] v;
            for (int i = 0; i < N; i++)
                v[4*i +: 4] = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
            step(v, 1'($urandom_range(0, 1)), 1'b0, "R7_random");
        end
        step('0, 1'b1, 1'b0, "R8");
        @(negedge clk);
        check_out();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule